// File: doc/BRIEF.md
# Strided Vector Register File

This block holds 128 words of 32 bits, organised as eight banks of sixteen, with each bank treated as a 4x4 grid addressed by a column digit and a row digit. A register's flat index is `bank*16 + col*4 + row`. Each port takes a small access descriptor: a bank, a start column, a start row, an element count from one to four, and an orientation flag. Together these select a short vector that runs either down a column or across a row of one bank.

The read port is combinational. It returns four 32-bit lanes, with lane i on bits `[32*i+31 : 32*i]`. The write port updates the addressed lanes on the next rising clock edge.

Either port can be marked as serving a memory transfer. A read marked this way feeds a store, and a write marked this way is fed by a load. Such a transfer is limited to a single element or a full quad, and a quad transfer must use a 16-byte-aligned byte address. Accesses that break the shape or alignment rules are flagged. An illegal read returns zeros, and an illegal write leaves every register untouched.

Top module: `vreg_grid_file`

## Requirements
- R1: While `rst` is high at a rising edge, all 128 registers are cleared to zero.
- R2: With orientation flag 0 (column-wise), lane i of an access starting at (bank m, column c, row r) is the register at bank m, column c, row r+i.
- R3: With orientation flag 1 (row-wise), lane i of an access starting at (bank m, column c, row r) is the register at bank m, column c+i, row r.
- R4: Let s be the start index along the orientation axis (the row for column-wise, the column for row-wise). An access is legal only when it matches one of these shapes: a count of 1 with any s; a count of 2 with s of 0 or 2; a count of 3 with s of 0 or 1; a count of 4 with s of 0. Every other count (0, 5, 6 or 7) and every other start is flagged on `rd_bad` or `wr_bad`.
- R5: An access flagged bad or misaligned returns zero on all four read lanes, or for a write it changes no register.
- R6: Read lanes whose index is at or above the element count are driven to zero.
- R7: A memory-marked access (`rd_to_mem` or `wr_from_mem` high) whose count is 2 or 3 is flagged bad.
- R8: A memory-marked access with a count of 4 and a byte address whose low four bits are not all zero raises its misaligned flag in the same cycle. A single-element memory access is never flagged misaligned.
- R9: A legal write with `wr_en` high updates the addressed registers at the next rising edge. A read of the same register in the same cycle returns the old value. With `wr_en` low, nothing changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_bank | input | 3 | Read bank |
| rd_col | input | 2 | Read start column |
| rd_row | input | 2 | Read start row |
| rd_cnt | input | 3 | Read element count |
| rd_by_row | input | 1 | Read orientation: 0 column-wise, 1 row-wise |
| rd_to_mem | input | 1 | Read serves a memory store |
| rd_addr | input | 32 | Store byte address |
| rd_lanes | output | 128 | Four read lanes, lane i at bits 32*i |
| rd_bad | output | 1 | Read shape illegal |
| rd_misaligned | output | 1 | Store quad address misaligned |
| wr_en | input | 1 | Write request |
| wr_bank | input | 3 | Write bank |
| wr_col | input | 2 | Write start column |
| wr_row | input | 2 | Write start row |
| wr_cnt | input | 3 | Write element count |
| wr_by_row | input | 1 | Write orientation: 0 column-wise, 1 row-wise |
| wr_from_mem | input | 1 | Write is fed by a memory load |
| wr_addr | input | 32 | Load byte address |
| wr_data | input | 128 | Four write lanes, lane i at bits 32*i |
| wr_bad | output | 1 | Write shape illegal |
| wr_misaligned | output | 1 | Load quad address misaligned |

## Verification
A corrupted register, or a lane steered to the wrong register, stays invisible until a later read covers that location. The bench therefore follows writes with reads in both orientations, so that an error surfaces one cycle after the faulty edge. A wrong legality or alignment decision shows in the same cycle: it appears on the flags and as non-zero tail or illegal lanes. A write that leaks past the shape check is caught by the next read of the register it touched.

// File: rtl/vreg_grid_file.sv
module vreg_grid_file #(
  parameter int W = 32,
  parameter int BANKS = 8,
  parameter int AW = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [$clog2(BANKS)-1:0]   rd_bank,
  input  logic [1:0]                 rd_col,
  input  logic [1:0]                 rd_row,
  input  logic [2:0]                 rd_cnt,
  input  logic                       rd_by_row,
  input  logic                       rd_to_mem,
  input  logic [AW-1:0]              rd_addr,
  output logic [4*W-1:0]             rd_lanes,
  output logic                       rd_bad,
  output logic                       rd_misaligned,
  input  logic                       wr_en,
  input  logic [$clog2(BANKS)-1:0]   wr_bank,
  input  logic [1:0]                 wr_col,
  input  logic [1:0]                 wr_row,
  input  logic [2:0]                 wr_cnt,
  input  logic                       wr_by_row,
  input  logic                       wr_from_mem,
  input  logic [AW-1:0]              wr_addr,
  input  logic [4*W-1:0]             wr_data,
  output logic                       wr_bad,
  output logic                       wr_misaligned
);
  localparam int BW = $clog2(BANKS);
  localparam int REGS = BANKS * 16;
  localparam int IW = BW + 4;

  logic [REGS-1:0][W-1:0] mem;

  function automatic logic shape_ok(input logic [1:0] s, input logic [2:0] n, input logic m);
    logic [3:0] sum;
    sum = {2'b00, s} + {1'b0, n};
    return (n != 3'd0) && (sum <= 4'd4) && !(n == 3'd2 && s[0])
           && !(m && (n == 3'd2 || n == 3'd3));
  endfunction

  function automatic logic [IW-1:0] reg_at(input logic [BW-1:0] b, input logic [1:0] c,
                                           input logic [1:0] r, input logic by_row,
                                           input logic [1:0] i);
    return by_row ? {b, c + i, r} : {b, c, r + i};
  endfunction

  logic rd_go, wr_go;

  assign rd_bad        = !shape_ok(rd_by_row ? rd_col : rd_row, rd_cnt, rd_to_mem);
  assign wr_bad        = !shape_ok(wr_by_row ? wr_col : wr_row, wr_cnt, wr_from_mem);
  assign rd_misaligned = rd_to_mem && rd_cnt == 3'd4 && rd_addr[3:0] != 4'd0;
  assign wr_misaligned = wr_from_mem && wr_cnt == 3'd4 && wr_addr[3:0] != 4'd0;
  assign rd_go         = !rd_bad && !rd_misaligned;
  assign wr_go         = wr_en && !wr_bad && !wr_misaligned;

  always_comb begin
    rd_lanes = '0;
    for (int i = 0; i < 4; i++)
      if (rd_go && i < int'(rd_cnt))
        rd_lanes[i*W +: W] = mem[reg_at(rd_bank, rd_col, rd_row, rd_by_row, 2'(i))];
  end

  always_ff @(posedge clk) begin
    if (rst) mem <= '0;
    else if (wr_go)
      for (int i = 0; i < 4; i++)
        if (i < int'(wr_cnt))
          mem[reg_at(wr_bank, wr_col, wr_row, wr_by_row, 2'(i))] <= wr_data[i*W +: W];
  end
endmodule

module vreg_grid_file_chk #(
  parameter int W = 32,
  parameter int REGS = 128,
  parameter int AW = 32
) (
  input logic                   clk,
  input logic                   rst,
  input logic [2:0]             rd_cnt,
  input logic [4*W-1:0]         rd_lanes,
  input logic                   rd_bad,
  input logic                   rd_misaligned,
  input logic                   wr_en,
  input logic [2:0]             wr_cnt,
  input logic                   wr_from_mem,
  input logic [AW-1:0]          wr_addr,
  input logic                   wr_bad,
  input logic                   wr_misaligned,
  input logic [REGS-1:0][W-1:0] mem
);
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> mem == '0);
  assert_rd_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_bad || rd_misaligned) |-> rd_lanes == '0);
  assert_wr_block_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_en && (wr_bad || wr_misaligned))) |-> $stable(mem));
  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wr_en)) |-> $stable(mem));
  assert_tail1_R6: assert property (@(posedge clk) disable iff (rst)
    rd_cnt == 3'd1 |-> rd_lanes[4*W-1:W] == '0);
  assert_tail2_R6: assert property (@(posedge clk) disable iff (rst)
    rd_cnt == 3'd2 |-> rd_lanes[4*W-1:2*W] == '0);
  assert_tail3_R6: assert property (@(posedge clk) disable iff (rst)
    rd_cnt == 3'd3 |-> rd_lanes[4*W-1:3*W] == '0);
  assert_mem_shape_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_from_mem && (wr_cnt == 3'd2 || wr_cnt == 3'd3)) |-> wr_bad);
  assert_align_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_from_mem && wr_cnt == 3'd4 && wr_addr[3:0] != 4'd0) |-> wr_misaligned);
  assert_single_align_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_cnt == 3'd1) |-> !wr_misaligned);
endmodule

bind vreg_grid_file vreg_grid_file_chk #(.W(W), .REGS(REGS), .AW(AW)) chk_i (
  .clk(clk), .rst(rst), .rd_cnt(rd_cnt), .rd_lanes(rd_lanes), .rd_bad(rd_bad),
  .rd_misaligned(rd_misaligned), .wr_en(wr_en), .wr_cnt(wr_cnt),
  .wr_from_mem(wr_from_mem), .wr_addr(wr_addr), .wr_bad(wr_bad),
  .wr_misaligned(wr_misaligned), .mem(mem)
);

// File: tb/vreg_grid_file_tb_top.sv
`timescale 1ns/1ps
module vreg_grid_file_tb_top;
  logic clk = 0, rst = 1;
  always #4 clk = ~clk;

  logic [2:0] rd_bank, wr_bank, rd_cnt, wr_cnt;
  logic [1:0] rd_col, rd_row, wr_col, wr_row;
  logic rd_by_row, rd_to_mem, wr_en, wr_by_row, wr_from_mem;
  logic [31:0] rd_addr, wr_addr;
  logic [127:0] rd_lanes, wr_data;
  logic rd_bad, rd_misaligned, wr_bad, wr_misaligned;

  vreg_grid_file dut_i (.*);

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] model [128];

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit legal(logic [1:0] s, logic [2:0] n, bit m);
    bit ok;
    case (n)
      3'd1: ok = 1;
      3'd2: ok = (s == 0 || s == 2);
      3'd3: ok = (s <= 1);
      3'd4: ok = (s == 0);
      default: ok = 0;
    endcase
    if (m && (n == 2 || n == 3)) ok = 0;
    return ok;
  endfunction

  function automatic bit misal(bit m, logic [2:0] n, logic [31:0] a);
    return m && n == 4 && a[3:0] != 0;
  endfunction

  function automatic int addr_of(logic [2:0] b, logic [1:0] c, logic [1:0] r, bit by_row, int i);
    int cc, rr;
    cc = by_row ? (c + i) % 4 : c;
    rr = by_row ? r : (r + i) % 4;
    return b * 16 + cc * 4 + rr;
  endfunction

  function automatic logic [127:0] exp_read();
    logic [127:0] v = '0;
    if (legal(rd_by_row ? rd_col : rd_row, rd_cnt, rd_to_mem) && !misal(rd_to_mem, rd_cnt, rd_addr))
      for (int i = 0; i < rd_cnt; i++)
        v[i*32 +: 32] = model[addr_of(rd_bank, rd_col, rd_row, rd_by_row, i)];
    return v;
  endfunction

  task automatic idle();
    wr_en = 0; wr_bank = 0; wr_col = 0; wr_row = 0; wr_cnt = 1; wr_by_row = 0;
    wr_from_mem = 0; wr_addr = 0; wr_data = '0;
    rd_bank = 0; rd_col = 0; rd_row = 0; rd_cnt = 1; rd_by_row = 0; rd_to_mem = 0; rd_addr = 0;
  endtask

  task automatic step(string tag);
    bit wok;
    #1;
    chk({tag, " read lanes R2 R3 R5 R6"}, rd_lanes, exp_read());
    chk("R4 R7 rd_bad", {127'd0, rd_bad}, {127'd0, !legal(rd_by_row ? rd_col : rd_row, rd_cnt, rd_to_mem)});
    chk("R4 R7 wr_bad", {127'd0, wr_bad}, {127'd0, !legal(wr_by_row ? wr_col : wr_row, wr_cnt, wr_from_mem)});
    chk("R8 rd_misaligned", {127'd0, rd_misaligned}, {127'd0, misal(rd_to_mem, rd_cnt, rd_addr)});
    chk("R8 wr_misaligned", {127'd0, wr_misaligned}, {127'd0, misal(wr_from_mem, wr_cnt, wr_addr)});
    wok = wr_en && legal(wr_by_row ? wr_col : wr_row, wr_cnt, wr_from_mem)
          && !misal(wr_from_mem, wr_cnt, wr_addr);
    @(posedge clk);
    if (wok)
      for (int i = 0; i < wr_cnt; i++)
        model[addr_of(wr_bank, wr_col, wr_row, wr_by_row, i)] = wr_data[i*32 +: 32];
    @(negedge clk);
  endtask

  function automatic logic [2:0] pick_cnt();
    int k = $urandom_range(0, 9);
    return (k < 8) ? 3'(1 + k % 4) : 3'($urandom_range(0, 7));
  endfunction

  function automatic logic [31:0] pick_addr();
    logic [31:0] a = $urandom;
    if ($urandom_range(0, 1) == 0) a[3:0] = 0;
    return a;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1a2b3c));
    for (int i = 0; i < 128; i++) model[i] = 0;
    idle();
    wr_en = 1; wr_cnt = 4; wr_data = {4{32'hdead_beef}};
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    idle();
    // R1: every quad column reads zero after reset
    for (int b = 0; b < 8; b++)
      for (int c = 0; c < 4; c++) begin
        rd_bank = 3'(b); rd_col = 2'(c); rd_row = 0; rd_cnt = 4; rd_by_row = 0;
        #1; chk("R1 reset clear", rd_lanes, '0);
        @(negedge clk);
      end
    // R2/R9: column quad write, same-cycle read returns old value
    wr_en = 1; wr_bank = 3; wr_col = 2; wr_row = 0; wr_cnt = 4; wr_by_row = 0;
    wr_data = {32'h44, 32'h33, 32'h22, 32'h11};
    rd_bank = 3; rd_col = 2; rd_row = 0; rd_cnt = 4; rd_by_row = 0;
    #1; chk("R9 old value on collision", rd_lanes, '0);
    step("R9 collide");
    idle();
    // R3: row read crossing that column picks one element each
    rd_bank = 3; rd_col = 0; rd_row = 1; rd_cnt = 4; rd_by_row = 1;
    #1; chk("R3 row read", rd_lanes, {32'h0, 32'h22, 32'h0, 32'h0});
    @(negedge clk);
    rd_by_row = 0; rd_col = 2; rd_row = 2; rd_cnt = 2;
    #1; chk("R2 R6 pair", rd_lanes, {64'h0, 32'h44, 32'h33});
    @(negedge clk);
    // R5: bad pair start blocks the write
    wr_en = 1; wr_bank = 3; wr_col = 2; wr_row = 1; wr_cnt = 2; wr_data = '1;
    step("R5 blocked");
    idle();
    rd_bank = 3; rd_col = 2; rd_row = 0; rd_cnt = 4;
    #1; chk("R5 blocked write", rd_lanes, {32'h44, 32'h33, 32'h22, 32'h11});
    @(negedge clk);
    // R8: misaligned quad load is blocked; single is fine
    wr_en = 1; wr_from_mem = 1; wr_bank = 5; wr_col = 1; wr_row = 0; wr_cnt = 4;
    wr_addr = 32'h104; wr_data = '1;
    step("R8 quad misaligned");
    wr_cnt = 1; wr_row = 3; wr_addr = 32'h106; wr_data = 128'h7;
    step("R8 single");
    idle();
    rd_bank = 5; rd_col = 1; rd_row = 0; rd_cnt = 4;
    #1; chk("R8 blocked quad, single landed", rd_lanes, {32'h7, 96'h0});
    @(negedge clk);
    // random mix
    for (int n = 0; n < 1500; n++) begin
      wr_en = ($urandom_range(0, 3) != 0);
      wr_bank = 3'($urandom); wr_col = 2'($urandom); wr_row = 2'($urandom);
      wr_cnt = pick_cnt(); wr_by_row = 1'($urandom);
      wr_from_mem = ($urandom_range(0, 3) == 0); wr_addr = pick_addr();
      wr_data = {$urandom, $urandom, $urandom, $urandom};
      rd_bank = 3'($urandom); rd_col = 2'($urandom); rd_row = 2'($urandom);
      rd_cnt = pick_cnt(); rd_by_row = 1'($urandom);
      rd_to_mem = ($urandom_range(0, 3) == 0); rd_addr = pick_addr();
      if (n % 5 == 0) begin
        rd_bank = wr_bank; rd_col = wr_col; rd_row = wr_row; rd_by_row = wr_by_row;
      end
      step("random");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule